// File: doc/BRIEF.md
# Multiplexed LCD Scan Controller

This block scans a 1/8-duty LCD with 4-level bias. It is clocked by the internal drive clock, which runs at 32 times the frame rate, so each of the 8 common rows lasts 4 clocks. For each row the block places the row index on an address port to an external synchronous-read display memory. One clock later the 64-bit row word comes back. From it the block computes a 2-bit drive-level code for every common and segment output. An analog stage outside the block turns each code into the matching bias voltage.

The drive polarity flips on every frame, and the polarity level itself is the frame sync output. A device strapped as master drives this signal. A device with any other strap setting is a slave: it synchronises the sync input, and on each edge it restarts its row scan and takes its polarity from the new level.

Two inputs override normal drive. Blanking darkens all segments while the commons keep scanning. Power-on reset holds every output at a fixed dark level. When either input is released, the scan restarts at row 0 and row 0 is shown dark. After a reset release the first frame has the inverted polarity.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: Rows are visited in the order 0,1,...,7,0,... on `row_addr_o`, each held for exactly 4 clocks; the memory answers one clock after the address.
- R2: `fsync_o` equals the frame polarity (0 = polarity A, 1 = polarity B) and inverts each time row 7 is left for row 0, giving a period of two frames (64 clocks).
- R3: With `cs_i` = 2'b00 the device is master and `fsync_oe_o` is 1; any other strap value makes it a slave with `fsync_oe_o` = 0.
- R4: Level code on every output: 00 = GND, 01 = low mid-level, 10 = high mid-level, 11 = VDSP. Common k occupies `com_o[2k+1:2k]`. In polarity A the scanned common is 11 and the others 01; in polarity B the scanned common is 00 and the others 10.
- R5: Segment j occupies `seg_o[2j+1:2j]` and shows bit j of the row word: in polarity A a 1 gives 00 and a 0 gives 10; in polarity B a 1 gives 11 and a 0 gives 01. All outputs refresh at the clock edge ending the second clock of each row.
- R6: While `blank_i` is 1, no segment shows a select level (00 or 11), whatever the memory holds.
- R7: One clock after `por_i` is sampled 1, every common and every segment code is 01, whatever `blank_i` is, and it stays so while `por_i` stays 1.
- R8: The first clock edge that samples `por_i` low after it was high, or `blank_i` low after it was high, restarts the scan: row 0 and an inverted polarity (a sync edge) are visible one clock later; row 0 is displayed dark, and row 1 shows memory data.
- R9: After a reset release the first frame has polarity B (`fsync_o` = 1).
- R10: A slave passes `fsync_i` through two synchronising flops; each level change restarts the scan at row 0 with the polarity set to the new level, visible three clocks after the change.
- R11: In a slave, a reset or blanking release is held pending until the next sync edge, and the row 0 that follows that edge is displayed dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal drive clock, 32 per frame |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 2 | Strap pins: 00 selects master |
| por_i | input | 1 | Power-on-reset hold, active high |
| blank_i | input | 1 | Display blanking, active high |
| fsync_i | input | 1 | Frame sync from master (used by slave) |
| fsync_o | output | 1 | Frame sync / current polarity |
| fsync_oe_o | output | 1 | Drive enable for frame sync pin |
| row_addr_o | output | 3 | Row index to the display memory |
| row_data_i | input | 64 | Row word, one clock after the address |
| com_o | output | 16 | Common level codes, 2 bits each |
| seg_o | output | 128 | Segment level codes, 2 bits each |

## Verification
A restart from a released blank or reset can land on the same clock as the natural row-7 wrap. In a slave, a pending release can meet a sync-input edge. Both cases change polarity, row and the dark-row flag at once. The bench releases blanking at arbitrary phases of the scan and, in slave mode, toggles the sync input while a release is pending or just occurring. On every clock a behavioural model predicts the full output set, and any case where one function wrongly takes priority over the other is judged against that prediction.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_LO   = 2'b01;
  localparam lvl_t LVL_HI   = 2'b10;
  localparam lvl_t LVL_VDSP = 2'b11;

  // common line: scanned row takes a rail, others a mid-level
  function automatic lvl_t com_level(input logic sel, input logic pol);
    if (sel) return pol ? LVL_GND : LVL_VDSP;
    return pol ? LVL_HI : LVL_LO;
  endfunction

  // segment line: lit pixel takes the rail opposite the common
  function automatic lvl_t seg_level(input logic lit, input logic pol);
    if (lit) return pol ? LVL_VDSP : LVL_GND;
    return pol ? LVL_LO : LVL_HI;
  endfunction
endpackage

// File: rtl/lcd_scan_sync.sv
module lcd_scan_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic por_i,
  input  logic blank_i,
  input  logic fsync_i,
  output logic release_o,
  output logic fs_edge_o,
  output logic fs_level_o
);
  logic                 por_q;
  logic                 blk_q;
  logic [SYNC_STAGES:0] fs_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q   <= 1'b1;
      blk_q   <= 1'b1;
      fs_pipe <= '0;
    end else begin
      por_q   <= por_i;
      blk_q   <= blank_i;
      fs_pipe <= {fs_pipe[SYNC_STAGES-1:0], fsync_i};
    end
  end

  assign release_o  = !por_i && (por_q || (blk_q && !blank_i));
  assign fs_edge_o  = fs_pipe[SYNC_STAGES-1] ^ fs_pipe[SYNC_STAGES];
  assign fs_level_o = fs_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int ROWS         = 8,
  parameter int CLKS_PER_ROW = 4,
  parameter int ROW_W        = 3,
  parameter int PH_W         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic             master_i,
  input  logic             release_i,
  input  logic             fs_edge_i,
  input  logic             fs_level_i,
  output logic [ROW_W-1:0] row_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             pol_o,
  output logic             dark_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(CLKS_PER_ROW - 1);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      row_o   <= '0;
      phase_o <= '0;
      pol_o   <= 1'b0;
      dark_o  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (phase_o == LAST_PH) begin
        phase_o <= '0;
        dark_o  <= 1'b0;
        if (row_o == LAST_ROW) begin
          row_o <= '0;
          pol_o <= ~pol_o;
        end else begin
          row_o <= row_o + 1'b1;
        end
      end else begin
        phase_o <= phase_o + 1'b1;
      end

      if (master_i) begin
        if (release_i) begin
          row_o   <= '0;
          phase_o <= '0;
          pol_o   <= ~pol_o;
          dark_o  <= 1'b1;
        end
      end else begin
        if (release_i) pend <= 1'b1;
        if (fs_edge_i) begin
          row_o   <= '0;
          phase_o <= '0;
          pol_o   <= fs_level_i;
          dark_o  <= pend | release_i;
          pend    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
  import lcd_scan_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int SEGS      = 64,
  parameter int ROW_W     = 3,
  parameter int PH_W      = 2,
  parameter int UPD_PHASE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              blank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              pol_i,
  input  logic              dark_i,
  input  logic [SEGS-1:0]   data_i,
  output logic [2*ROWS-1:0] com_o,
  output logic [2*SEGS-1:0] seg_o
);
  logic upd;
  assign upd = (phase_i == PH_W'(UPD_PHASE));

  for (genvar k = 0; k < ROWS; k++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst || hold_i)
        com_o[2*k +: 2] <= LVL_LO;
      else if (upd)
        com_o[2*k +: 2] <= com_level(row_i == ROW_W'(k), pol_i);
    end
  end

  for (genvar j = 0; j < SEGS; j++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst || hold_i)
        seg_o[2*j +: 2] <= LVL_LO;
      else if (upd)
        seg_o[2*j +: 2] <= seg_level(data_i[j] & ~blank_i & ~dark_i, pol_i);
    end
  end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int ROWS         = 8,
  parameter int SEGS         = 64,
  parameter int CLKS_PER_ROW = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int PH_W        = (CLKS_PER_ROW > 1) ? $clog2(CLKS_PER_ROW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cs_i,
  input  logic              por_i,
  input  logic              blank_i,
  input  logic              fsync_i,
  output logic              fsync_o,
  output logic              fsync_oe_o,
  output logic [ROW_W-1:0]  row_addr_o,
  input  logic [SEGS-1:0]   row_data_i,
  output logic [2*ROWS-1:0] com_o,
  output logic [2*SEGS-1:0] seg_o
);
  logic             master;
  logic             rel;
  logic             fs_edge;
  logic             fs_level;
  logic [ROW_W-1:0] row;
  logic [PH_W-1:0]  phase;
  logic             pol;
  logic             dark;

  assign master = (cs_i == 2'b00);

  lcd_scan_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .por_i(por_i), .blank_i(blank_i), .fsync_i(fsync_i),
    .release_o(rel), .fs_edge_o(fs_edge), .fs_level_o(fs_level)
  );

  lcd_scan_timer #(.ROWS(ROWS), .CLKS_PER_ROW(CLKS_PER_ROW), .ROW_W(ROW_W), .PH_W(PH_W)) u_timer (
    .clk(clk), .rst(rst), .hold_i(por_i), .master_i(master), .release_i(rel),
    .fs_edge_i(fs_edge), .fs_level_i(fs_level),
    .row_o(row), .phase_o(phase), .pol_o(pol), .dark_o(dark)
  );

  lcd_scan_drive #(.ROWS(ROWS), .SEGS(SEGS), .ROW_W(ROW_W), .PH_W(PH_W), .UPD_PHASE(1)) u_drive (
    .clk(clk), .rst(rst), .hold_i(por_i), .blank_i(blank_i), .row_i(row),
    .phase_i(phase), .pol_i(pol), .dark_i(dark), .data_i(row_data_i),
    .com_o(com_o), .seg_o(seg_o)
  );

  assign row_addr_o = row;
  assign fsync_o    = pol;
  assign fsync_oe_o = master;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int ROWS         = 8,
  parameter int SEGS         = 64,
  parameter int CLKS_PER_ROW = 4,
  parameter int ROW_W        = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              por_i,
  input logic              blank_i,
  input logic              fsync_o,
  input logic              fsync_oe_o,
  input logic [ROW_W-1:0]  row_addr_o,
  input logic [2*ROWS-1:0] com_o,
  input logic [2*SEGS-1:0] seg_o
);
  localparam int LIM   = 2 * CLKS_PER_ROW + 1;
  localparam int CNT_W = $clog2(LIM + 1);

  logic [ROWS-1:0]  com_sel;
  logic [SEGS-1:0]  seg_sel;
  logic [CNT_W-1:0] blk_run;

  for (genvar k = 0; k < ROWS; k++) begin : g_cs
    assign com_sel[k] = (com_o[2*k +: 2] == 2'b00) || (com_o[2*k +: 2] == 2'b11);
  end
  for (genvar j = 0; j < SEGS; j++) begin : g_ss
    assign seg_sel[j] = (seg_o[2*j +: 2] == 2'b00) || (seg_o[2*j +: 2] == 2'b11);
  end

  always_ff @(posedge clk) begin
    if (rst || por_i || !blank_i) blk_run <= '0;
    else if (blk_run != CNT_W'(LIM)) blk_run <= blk_run + 1'b1;
  end

  p_row_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_addr_o) |-> (row_addr_o == $past(row_addr_o) + 1'b1 || row_addr_o == '0));

  p_one_common_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_sel));

  p_blank_dark_r6: assert property (@(posedge clk) disable iff (rst)
    (blk_run == CNT_W'(LIM)) |-> (seg_sel == '0));

  p_por_static_r7: assert property (@(posedge clk) disable iff (rst)
    por_i |=> (com_o == {ROWS{2'b01}} && seg_o == {SEGS{2'b01}}));

  p_frame_b_after_por_r9: assert property (@(posedge clk) disable iff (rst)
    (fsync_oe_o && $fell(por_i)) |=> fsync_o);
endmodule

bind lcd_scan_ctrl lcd_scan_chk #(
  .ROWS(ROWS), .SEGS(SEGS), .CLKS_PER_ROW(CLKS_PER_ROW), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .por_i(por_i), .blank_i(blank_i), .fsync_o(fsync_o),
  .fsync_oe_o(fsync_oe_o), .row_addr_o(row_addr_o), .com_o(com_o), .seg_o(seg_o)
);

// File: tb/test_lcd_scan_ctrl.sv
module test_lcd_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int SEGS = 64;
  localparam int CPR  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cs_i = 2'b00;
  logic              por_i = 1'b1;
  logic              blank_i = 1'b1;
  logic              fsync_i = 1'b0;
  logic              fsync_o, fsync_oe_o;
  logic [2:0]        row_addr_o;
  logic [SEGS-1:0]   rdata = '0;
  logic [2*ROWS-1:0] com_o;
  logic [2*SEGS-1:0] seg_o;
  logic [SEGS-1:0]   ram [ROWS];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_ctrl i_lcd_scan_ctrl (
    .clk(clk), .rst(rst), .cs_i(cs_i), .por_i(por_i), .blank_i(blank_i),
    .fsync_i(fsync_i), .fsync_o(fsync_o), .fsync_oe_o(fsync_oe_o),
    .row_addr_o(row_addr_o), .row_data_i(rdata), .com_o(com_o), .seg_o(seg_o)
  );

  always @(posedge clk) rdata <= ram[row_addr_o];

  // ---------------- behavioural reference ----------------
  int m_row = 0, m_ph = 0, m_pol = 0;
  bit m_dark = 0, m_pend = 0, m_porq = 1, m_blkq = 1;
  bit m_fs1 = 0, m_fs2 = 0, m_fs3 = 0;
  logic [2*ROWS-1:0] m_com = {ROWS{2'b01}};
  logic [2*SEGS-1:0] m_seg = {SEGS{2'b01}};
  bit v_rel, v_edge, v_lvl;
  int o_row, o_ph, o_pol;

  function automatic logic [1:0] com_code(bit sel, int pol);
    case ({sel, pol[0]})
      2'b10:   return 2'b11;
      2'b11:   return 2'b00;
      2'b00:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] seg_code(bit lit, int pol);
    case ({lit, pol[0]})
      2'b10:   return 2'b00;
      2'b11:   return 2'b11;
      2'b00:   return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  always @(posedge clk) begin
    v_rel  = !por_i && (m_porq || (m_blkq && !blank_i));
    v_edge = (m_fs2 != m_fs3);
    v_lvl  = m_fs2;
    if (rst || por_i) begin
      m_com = {ROWS{2'b01}};
      m_seg = {SEGS{2'b01}};
    end else if (m_ph == 1) begin
      for (int k = 0; k < ROWS; k++) m_com[2*k +: 2] = com_code(k == m_row, m_pol);
      for (int j = 0; j < SEGS; j++)
        m_seg[2*j +: 2] = seg_code(rdata[j] && !blank_i && !m_dark, m_pol);
    end
    if (rst || por_i) begin
      m_row = 0; m_ph = 0; m_pol = 0; m_dark = 0; m_pend = 0;
    end else begin
      o_row = m_row; o_ph = m_ph; o_pol = m_pol;
      m_ph = (o_ph + 1) % CPR;
      if (o_ph == CPR - 1) begin
        m_dark = 0;
        m_row = (o_row + 1) % ROWS;
        if (o_row == ROWS - 1) m_pol = 1 - o_pol;
      end
      if (cs_i == 2'b00) begin
        if (v_rel) begin m_row = 0; m_ph = 0; m_pol = 1 - o_pol; m_dark = 1; end
      end else if (v_edge) begin
        m_row = 0; m_ph = 0; m_pol = v_lvl; m_dark = m_pend || v_rel; m_pend = 0;
      end else if (v_rel) begin
        m_pend = 1;
      end
    end
    if (rst) begin
      m_porq = 1; m_blkq = 1; m_fs1 = 0; m_fs2 = 0; m_fs3 = 0;
    end else begin
      m_porq = por_i; m_blkq = blank_i;
      m_fs3 = m_fs2; m_fs2 = m_fs1; m_fs1 = fsync_i;
    end
    cmp_on = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(row_addr_o === 3'(m_row), "R1 row index", 128'(row_addr_o), 128'(m_row));
      chk(fsync_o === m_pol[0], "R2 frame sync", 128'(fsync_o), 128'(m_pol));
      chk(fsync_oe_o === (cs_i == 2'b00), "R3 sync drive", 128'(fsync_oe_o), 128'(cs_i == 2'b00));
      chk(com_o === m_com, "R4 commons", 128'(com_o), 128'(m_com));
      chk(seg_o === m_seg, "R5 segments", seg_o, m_seg);
    end
  end

  function automatic bit no_seg_sel(logic [2*SEGS-1:0] s);
    for (int j = 0; j < SEGS; j++)
      if (s[2*j +: 2] == 2'b00 || s[2*j +: 2] == 2'b11) return 0;
    return 1;
  endfunction

  function automatic logic [SEGS-1:0] lit_map(logic [2*SEGS-1:0] s);
    logic [SEGS-1:0] r;
    for (int j = 0; j < SEGS; j++) r[j] = (s[2*j +: 2] == 2'b00) || (s[2*j +: 2] == 2'b11);
    return r;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    logic prev;
    for (int r = 0; r < ROWS; r++)
      ram[r] = {8{8'(8'h11 * (r + 1))}} ^ (64'h1 << (r * 9));
    step(3);
    rst = 1'b0;
    step(2);
    chk(com_o === {ROWS{2'b01}} && seg_o === {SEGS{2'b01}}, "R7 reset static",
        {com_o, seg_o[111:0]}, {16'h5555, {56{2'b01}}});
    chk(fsync_o === 1'b0, "R7 reset polarity", 128'(fsync_o), 128'(0));

    por_i = 1'b0;
    step(1);
    chk(fsync_o === 1'b1, "R9 first frame B", 128'(fsync_o), 128'(1));
    chk(row_addr_o === 3'd0, "R8 restart row", 128'(row_addr_o), 128'(0));
    step(40);
    chk(no_seg_sel(seg_o), "R6 blank dark", seg_o, 128'(0));

    blank_i = 1'b0;
    step(3);
    chk(no_seg_sel(seg_o), "R8 row 0 dark", seg_o, 128'(0));
    chk(com_o[1:0] === (fsync_o ? 2'b00 : 2'b11), "R4 row 0 selected",
        128'(com_o[1:0]), 128'(fsync_o ? 2'b00 : 2'b11));
    step(4);
    chk(lit_map(seg_o) === ram[1], "R8 row 1 data", 128'(lit_map(seg_o)), 128'(ram[1]));

    prev = fsync_o;
    t = 0;
    while (fsync_o === prev && t < 100) begin step(1); t++; end
    prev = fsync_o;
    t = 0;
    while (fsync_o === prev && t < 100) begin step(1); t++; end
    chk(t == ROWS * CPR, "R2 sync period", 128'(t), 128'(ROWS * CPR));

    step(37);
    blank_i = 1'b1;
    step(9);
    chk(no_seg_sel(seg_o), "R6 blank mid-frame", seg_o, 128'(0));
    blank_i = 1'b0;
    step(40);
    ram[3] = '1;
    ram[5] = '0;
    step(64);
    blank_i = 1'b1;
    step(5);
    blank_i = 1'b0;
    step(30);

    por_i = 1'b1;
    step(1);
    chk(com_o === {ROWS{2'b01}} && seg_o === {SEGS{2'b01}}, "R7 reset mid-run",
        {com_o, seg_o[111:0]}, {16'h5555, {56{2'b01}}});
    step(5);
    por_i = 1'b0;
    step(1);
    chk(fsync_o === 1'b1, "R9 frame B again", 128'(fsync_o), 128'(1));
    step(20);

    // slave operation
    por_i = 1'b1;
    cs_i = 2'b01;
    step(2);
    por_i = 1'b0;
    step(1);
    chk(fsync_oe_o === 1'b0, "R3 slave no drive", 128'(fsync_oe_o), 128'(0));
    step(10);
    fsync_i = 1'b1;
    step(3);
    chk(row_addr_o === 3'd0, "R10 slave resync row", 128'(row_addr_o), 128'(0));
    chk(fsync_o === 1'b1, "R10 slave polarity", 128'(fsync_o), 128'(1));
    step(2);
    chk(no_seg_sel(seg_o), "R11 pending dark row", seg_o, 128'(0));
    step(27);
    for (int f = 0; f < 5; f++) begin
      fsync_i = ~fsync_i;
      step(32);
    end
    blank_i = 1'b1;
    step(20);
    blank_i = 1'b0;
    step(25);
    fsync_i = ~fsync_i;
    step(5);
    chk(no_seg_sel(seg_o), "R11 blank pending dark", seg_o, 128'(0));
    step(50);
    fsync_i = ~fsync_i;
    step(19);
    fsync_i = ~fsync_i;
    step(40);

    done = 1;
    summary();
    $finish;
  end
endmodule